// File: doc/BRIEF.md
# SPI Transmit Write-Collision Guard

This block sits in front of the transmit shift register of an SPI-style controller. It decides, cycle by cycle, whether a serial transfer is under way. The rule it applies depends on whether the controller is master or slave and on the clock phase setting. A host write to the transmit register that falls outside a transfer is passed on: the data is latched as the new shift word and the shift engine gets a one-cycle load strobe.

A host write that falls inside a transfer is a collision. The shift word is left alone and the running transfer carries on. The written byte goes into a shadow register that the host can read back, and a sticky collision flag is raised. The host clears the flag by writing a 1 to it.

The block also produces the enable for the serial data output. A master always drives the line. A slave drives it only when it is selected and its transmit enable is set.

Top module: `spi_wcol_guard`

## Requirements
- R1: After reset, `wcol_o`, `load_o`, `tx_data_o` and `shadow_o` are all zero.
- R2: A write (`wr_tx_i`=1) outside a transfer window makes `load_o` 1 in the next cycle, and in that cycle `tx_data_o` equals the written data. `load_o` is 0 in every cycle that does not follow such a write.
- R3: A write inside a transfer window gives no load strobe in the next cycle and leaves `tx_data_o` unchanged.
- R4: A write inside a transfer window copies its data to `shadow_o` in the next cycle. Writes outside a window leave `shadow_o` unchanged.
- R5: In master mode (`master_i`=1) with `cpha_i`=0, the window opens in the cycle after an accepted write. It stays open up to and including the cycle in which `last_edge_i` is 1. A write in the cycle after that is accepted.
- R6: With `cpha_i`=1, in either mode, the window opens in the cycle in which `first_edge_i` is 1 and closes after the cycle in which `last_edge_i` is 1. A write made after a load but before the first edge is accepted.
- R7: In slave mode (`master_i`=0) with `cpha_i`=0, the window is open in every cycle in which `ss_ni` is 0, and closed in every cycle in which `ss_ni` is 1.
- R8: A collision sets `wcol_o` in the next cycle. `wcol_o` then stays 1 until a cycle with `wcol_clr_i`=1, and it reads 0 in the cycle after that. If a collision and a clear happen in the same cycle, the flag ends up 1.
- R9: `sdo_oe_o` is combinational. It is 1 in master mode. In slave mode it is 1 only when `ss_ni`=0 and `tx_en_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| cpha_i | input | 1 | Clock phase setting |
| ss_ni | input | 1 | Slave select, active low |
| tx_en_i | input | 1 | Slave transmit enable |
| wr_tx_i | input | 1 | Host write strobe for the transmit register |
| wr_data_i | input | DATA_W | Host write data |
| wcol_clr_i | input | 1 | Host writes 1 to clear the collision flag |
| first_edge_i | input | 1 | Pulse from the shift engine on the first SCLK edge |
| last_edge_i | input | 1 | Pulse from the shift engine on the last sample edge |
| load_o | output | 1 | One-cycle load strobe to the shift engine |
| tx_data_o | output | DATA_W | Word handed to the shift register |
| wcol_o | output | 1 | Sticky write-collision flag |
| shadow_o | output | DATA_W | Data of the most recent colliding write |
| sdo_oe_o | output | 1 | Serial data output enable |

## Verification
The assertions assume that `first_edge_i` and `last_edge_i` are single-cycle pulses from a well-behaved shift engine, so `last_edge_i` only follows a started transfer. They also assume that the mode and phase inputs hold steady across a transfer. The directed sequences keep to these rules by construction. The random phase changes mode and phase only after a last-edge pulse has closed the window, and it never raises both edge pulses in the same cycle. The reference model works out the window from the mode rules independently and is compared against the outputs on every clock.

// File: rtl/spi_wcol_pkg.sv
package spi_wcol_pkg;
  typedef enum logic [1:0] {
    WIN_SELECT = 2'd0,  // slave, phase 0: open while selected
    WIN_LOAD   = 2'd1,  // master, phase 0: open from load to last edge
    WIN_EDGE   = 2'd2   // phase 1: open from first edge to last edge
  } win_rule_e;

  function automatic win_rule_e pick_rule(input logic master, input logic cpha);
    if (cpha) return WIN_EDGE;
    if (master) return WIN_LOAD;
    return WIN_SELECT;
  endfunction
endpackage

// File: rtl/wcol_window.sv
module wcol_window
  import spi_wcol_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic cpha_i,
  input  logic ss_ni,
  input  logic accept_i,
  input  logic first_edge_i,
  input  logic last_edge_i,
  output logic in_prog_o
);
  win_rule_e rule;
  logic      busy_q, busy_d, start;

  assign rule = pick_rule(master_i, cpha_i);

  always_comb begin
    start = 1'b0;
    unique case (rule)
      WIN_LOAD:   start = accept_i;
      WIN_EDGE:   start = first_edge_i;
      default:    start = 1'b0;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    if (last_edge_i)  busy_d = 1'b0;
    else if (start)   busy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  always_comb begin
    unique case (rule)
      WIN_SELECT: in_prog_o = ~ss_ni;
      WIN_EDGE:   in_prog_o = busy_q | first_edge_i;
      default:    in_prog_o = busy_q;
    endcase
  end

  AST_SLAVE_SEL_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !cpha_i && !ss_ni) |-> in_prog_o);  // R7
  AST_SLAVE_DESEL_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !cpha_i && ss_ni) |-> !in_prog_o);  // R7
  AST_LOAD_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !cpha_i && accept_i && !last_edge_i) ##1 (master_i && !cpha_i) |-> in_prog_o);  // R5
  AST_FIRST_EDGE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpha_i && first_edge_i) |-> in_prog_o);  // R6
endmodule

// File: rtl/wcol_capture.sv
module wcol_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              in_prog_i,
  output logic              accept_o,
  output logic              collide_o,
  output logic              load_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] shadow_o
);
  logic              load_q;
  logic [DATA_W-1:0] tx_q, shadow_q;

  assign accept_o  = wr_i & ~in_prog_i;
  assign collide_o = wr_i &  in_prog_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= 1'b0;
      tx_q     <= '0;
      shadow_q <= '0;
    end else begin
      load_q <= accept_o;
      if (accept_o)  tx_q     <= data_i;
      if (collide_o) shadow_q <= data_i;
    end
  end

  assign load_o    = load_q;
  assign tx_data_o = tx_q;
  assign shadow_o  = shadow_q;

  AST_ACCEPT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !in_prog_i) |=> (load_o && tx_data_o == $past(data_i)));  // R2
  AST_COLLIDE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_prog_i) |=> (!load_o && $stable(tx_data_o)));  // R3
  AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_prog_i) |=> (shadow_o == $past(data_i)));  // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && in_prog_i) |=> $stable(shadow_o));  // R4
endmodule

// File: rtl/wcol_flag.sv
module wcol_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic collide_i,
  input  logic clr_i,
  output logic wcol_o
);
  logic wcol_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wcol_q <= 1'b0;
    else if (collide_i) wcol_q <= 1'b1;
    else if (clr_i)     wcol_q <= 1'b0;
  end

  assign wcol_o = wcol_q;

  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_i |=> wcol_o);  // R8
  AST_WCOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !clr_i) |=> wcol_o);  // R8
  AST_WCOL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !collide_i) |=> !wcol_o);  // R8
endmodule

// File: rtl/sdo_oe_ctl.sv
module sdo_oe_ctl (
  input  logic master_i,
  input  logic ss_ni,
  input  logic tx_en_i,
  output logic oe_o
);
  assign oe_o = master_i | (~ss_ni & tx_en_i);

  always_comb begin
    if (!master_i && (ss_ni || !tx_en_i))
      AST_SLAVE_OE_OFF: assert (!oe_o);  // R9
  end
endmodule

// File: rtl/spi_wcol_guard.sv
module spi_wcol_guard
  import spi_wcol_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              cpha_i,
  input  logic              ss_ni,
  input  logic              tx_en_i,
  input  logic              wr_tx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wcol_clr_i,
  input  logic              first_edge_i,
  input  logic              last_edge_i,
  output logic              load_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              wcol_o,
  output logic [DATA_W-1:0] shadow_o,
  output logic              sdo_oe_o
);
  logic in_prog, accept, collide;

  wcol_window u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .master_i     (master_i),
    .cpha_i       (cpha_i),
    .ss_ni        (ss_ni),
    .accept_i     (accept),
    .first_edge_i (first_edge_i),
    .last_edge_i  (last_edge_i),
    .in_prog_o    (in_prog)
  );

  wcol_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_tx_i),
    .data_i    (wr_data_i),
    .in_prog_i (in_prog),
    .accept_o  (accept),
    .collide_o (collide),
    .load_o    (load_o),
    .tx_data_o (tx_data_o),
    .shadow_o  (shadow_o)
  );

  wcol_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .collide_i (collide),
    .clr_i     (wcol_clr_i),
    .wcol_o    (wcol_o)
  );

  sdo_oe_ctl u_oe (
    .master_i (master_i),
    .ss_ni    (ss_ni),
    .tx_en_i  (tx_en_i),
    .oe_o     (sdo_oe_o)
  );

  AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_tx_i |=> !load_o);  // R2
endmodule

// File: tb/tb_spi_wcol_guard.sv
`timescale 1ns/1ps
module tb_spi_wcol_guard;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1, cpha = 1'b0, ss_n = 1'b1, tx_en = 1'b0;
  logic wr = 1'b0, clr = 1'b0, fe = 1'b0, le = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic load;
  logic [DW-1:0] txd, shd;
  logic wcol, oe;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_busy = 0, m_wcol = 0, m_load = 0;
  int m_tx = 0, m_sh = 0;

  always #5 clk = ~clk;

  spi_wcol_guard #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .cpha_i(cpha),
    .ss_ni(ss_n), .tx_en_i(tx_en), .wr_tx_i(wr), .wr_data_i(wdata),
    .wcol_clr_i(clr), .first_edge_i(fe), .last_edge_i(le),
    .load_o(load), .tx_data_o(txd), .wcol_o(wcol), .shadow_o(shd),
    .sdo_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_window();
    if (!master && !cpha) return !ss_n;
    if (cpha) return m_busy || fe;
    return m_busy;
  endfunction

  // drive one cycle at negedge, advance model at posedge, compare at next negedge
  task automatic cyc(input bit w, input int d, input bit c, input bit f, input bit l);
    bit win, acc, col;
    wr = w; wdata = DW'(d); clr = c; fe = f; le = l;
    #1;
    chk(oe == (master || (!ss_n && tx_en)), "R9", oe, master || (!ss_n && tx_en));
    win = model_window();
    acc = w && !win;
    col = w && win;
    @(posedge clk);
    m_load = acc;
    if (acc) m_tx = d & 8'hFF;
    if (col) m_sh = d & 8'hFF;
    if (col) m_wcol = 1;
    else if (c) m_wcol = 0;
    if (l) m_busy = 0;
    else if (cpha ? f : (master && acc)) m_busy = 1;
    @(negedge clk);
    chk(load == m_load, "R2", load, m_load);
    chk(int'(txd) == m_tx, "R3", txd, m_tx);
    chk(int'(shd) == m_sh, "R4", shd, m_sh);
    chk(wcol == m_wcol, "R8", wcol, m_wcol);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic clear_flag();
    cyc(0, 0, 1, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(wcol == 0 && load == 0 && txd == 0 && shd == 0, "R1", {wcol, load, txd != 0, shd != 0}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: master, phase 0
    master = 1; cpha = 0;
    cyc(1, 8'h11, 0, 0, 0);
    chk(load == 1 && txd == 8'h11, "R5 accept", txd, 8'h11);
    cyc(1, 8'h22, 0, 0, 0);
    chk(wcol == 1 && shd == 8'h22 && txd == 8'h11, "R5 collide after load", shd, 8'h22);
    clear_flag();
    chk(wcol == 0, "R8 cleared", wcol, 0);
    idle(3);
    cyc(1, 8'h33, 0, 0, 1);
    chk(wcol == 1 && load == 0, "R5 write on last edge collides", wcol, 1);
    cyc(1, 8'h44, 1, 0, 0);
    chk(load == 1 && txd == 8'h44 && wcol == 0, "R5 write after last edge accepted", txd, 8'h44);
    cyc(0, 0, 0, 0, 1);
    clear_flag();

    // R6: master, phase 1
    cpha = 1;
    cyc(1, 8'h55, 0, 0, 0);
    cyc(1, 8'h66, 0, 0, 0);
    chk(load == 1 && txd == 8'h66 && wcol == 0, "R6 pre-edge rewrite accepted", txd, 8'h66);
    cyc(1, 8'h77, 0, 1, 0);
    chk(wcol == 1 && shd == 8'h77 && txd == 8'h66, "R6 write on first edge collides", shd, 8'h77);
    cyc(1, 8'h78, 1, 0, 0);
    chk(wcol == 1 && shd == 8'h78, "R8 set wins over clear", wcol, 1);
    cyc(0, 0, 1, 0, 1);
    cyc(1, 8'h79, 0, 0, 0);
    chk(load == 1 && txd == 8'h79 && wcol == 0, "R6 closed after last edge", txd, 8'h79);

    // R6: slave, phase 1
    master = 0; ss_n = 0; tx_en = 1;
    cyc(0, 0, 0, 1, 0);
    cyc(1, 8'h9A, 0, 0, 0);
    chk(wcol == 1 && shd == 8'h9A, "R6 slave mid-transfer collides", shd, 8'h9A);
    cyc(0, 0, 1, 0, 1);

    // R7: slave, phase 0
    cpha = 0;
    cyc(1, 8'hA5, 0, 0, 0);
    chk(wcol == 1 && load == 0 && shd == 8'hA5, "R7 selected collides", shd, 8'hA5);
    clear_flag();
    ss_n = 1;
    cyc(1, 8'h5A, 0, 0, 0);
    chk(wcol == 0 && load == 1 && txd == 8'h5A, "R7 deselected accepted", txd, 8'h5A);
    tx_en = 0; ss_n = 0;
    #1 chk(oe == 0, "R9 slave without enable", oe, 0);
    tx_en = 1;
    #1 chk(oe == 1, "R9 slave selected and enabled", oe, 1);
    ss_n = 1;
    idle(1);

    // random phase: mode changes only with the window closed
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit f, l;
      r = $urandom_range(0, 99);
      if (r < 4 && !m_busy) begin
        master = 1'($urandom);
        cpha = 1'($urandom);
      end
      if ($urandom_range(0, 9) == 0) ss_n = ~ss_n;
      if ($urandom_range(0, 15) == 0) tx_en = ~tx_en;
      f = ($urandom_range(0, 9) == 0);
      l = !f && m_busy && ($urandom_range(0, 7) == 0);
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, 255),
          $urandom_range(0, 5) == 0, f, l);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule